// File: doc/BRIEF.md
# Turbo Branch Metric Unit

This unit sits at the front of a log-domain constituent decoder for an 8-state, rate-1/2 recursive systematic convolutional code. On each trellis step it accepts one soft systematic value, one soft parity value and one soft a-priori value for the information bit. It produces the branch metric for each of the four label pairs (u, p), with u, p in {+1, -1}. The metric is half of u times the a-priori value, plus half of the label-weighted channel values. The systematic label of a branch always equals u. The forward and backward recursion units select among these four values by branch label.

The channel values arrive already scaled by the channel reliability. They are signed two's-complement numbers with 2 integer and 2 fractional bits, 5 bits in all. The a-priori value is signed with 4 integer and 2 fractional bits, 7 bits in all. The unit does not halve with a shift. It keeps one more fractional bit instead, so each metric is an exact signed 8-bit number with 4 integer and 3 fractional bits. Numerically, a metric in LSBs of 1/8 equals u·(A+S) + p·P, where A, S and P are the raw input integers in LSBs of 1/4.

A two-state controller governs the output. ST_IDLE means no fresh metrics are presented. ST_STREAM means the metric registers hold the result of the step accepted on the previous clock. The transitions are:
- ST_IDLE to ST_STREAM on an accepted step.
- ST_STREAM to itself on a back-to-back step.
- ST_STREAM to ST_IDLE when no step is presented.
- ST_IDLE to itself while no step is presented.

Top module: `turbo_bmu`

## Requirements
- R1: While rst_n is low, and on the first clock after it rises with no step presented, out_valid is 0 and all four metric outputs are 0.
- R2: After an accepted step, out_m_pp (u=+1, p=+1) equals A+S+P, in units of 1/8.
- R3: After an accepted step, out_m_pn (u=+1, p=-1) equals A+S-P, in units of 1/8.
- R4: After an accepted step, out_m_np (u=-1, p=+1) equals -A-S+P, in units of 1/8.
- R5: After an accepted step, out_m_nn (u=-1, p=-1) equals -A-S-P, in units of 1/8.
- R6: out_valid is 1 in exactly the cycle after a clock edge at which in_valid was 1, and 0 after an edge at which in_valid was 0. The latency is one clock.
- R7: When in_valid is 0 at a clock edge, all four metric outputs keep their previous values whatever in_sys, in_par and in_apr carry.
- R8: Full-scale inputs give exact metrics with no wrap. A=-64, S=-16, P=-16 gives out_m_nn=+96 (12.0) and out_m_pp=-96. No metric magnitude ever exceeds 96.
- R9: Whenever out_valid is 1, out_m_nn equals -out_m_pp and out_m_np equals -out_m_pn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Step strobe; inputs are accepted on a rising edge while high |
| in_sys | input | 5 | Scaled systematic soft value, signed, 2 fractional bits |
| in_par | input | 5 | Scaled parity soft value, signed, 2 fractional bits |
| in_apr | input | 7 | A-priori soft value of u, signed, 2 fractional bits |
| out_valid | output | 1 | Metrics present the previous step |
| out_m_pp | output | 8 | Metric for u=+1, p=+1, signed, 3 fractional bits |
| out_m_pn | output | 8 | Metric for u=+1, p=-1, signed, 3 fractional bits |
| out_m_np | output | 8 | Metric for u=-1, p=+1, signed, 3 fractional bits |
| out_m_nn | output | 8 | Metric for u=-1, p=-1, signed, 3 fractional bits |

## Verification
The bench drives the most negative and most positive codes on all three inputs. A datapath that is one bit too narrow, or that fails to sign-extend, would then wrap ±96 to a small or opposite-signed value. Idle gaps carry changing input values, so a register that loads without the strobe would pick up garbage in cycles where the metrics should hold. Back-to-back steps follow isolated steps, which exposes a controller that drops out_valid between consecutive steps or raises it one cycle late. Swapped label pairs, or a sign inverted on only one of the two channel terms, show up as a mismatch on a single metric port against the behavioural model.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } bmu_state_t;

    // label index: bit1 = u is -1, bit0 = parity label is -1
    localparam int unsigned LBL_COUNT = 4;
    localparam int unsigned LBL_PP    = 0;
    localparam int unsigned LBL_PN    = 1;
    localparam int unsigned LBL_NP    = 2;
    localparam int unsigned LBL_NN    = 3;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bmu_align.sv
// Sign-extends a soft value and moves its binary point to a common position.
module bmu_align #(
    parameter int unsigned IN_W  = 5,
    parameter int unsigned SHIFT = 0,
    parameter int unsigned OUT_W = 8
) (
    input  logic signed [IN_W-1:0]  in_v,
    output logic signed [OUT_W-1:0] out_v
);

    logic signed [OUT_W-1:0] ext_v;

    always_comb begin
        ext_v = OUT_W'(in_v);
        out_v = ext_v <<< SHIFT;
    end

endmodule

// File: rtl/bmu_combine.sv
// One branch metric: signed combination of the u-weighted term and the parity term.
module bmu_combine #(
    parameter int unsigned US_W  = 8,
    parameter int unsigned PR_W  = 5,
    parameter int unsigned SUM_W = 9,
    parameter int unsigned OUT_W = 8,
    parameter bit          U_NEG = 1'b0,
    parameter bit          P_NEG = 1'b0
) (
    input  logic signed [US_W-1:0]  us_v,
    input  logic signed [PR_W-1:0]  pr_v,
    output logic signed [OUT_W-1:0] met_v
);

    logic signed [SUM_W-1:0] us_x;
    logic signed [SUM_W-1:0] pr_x;
    logic signed [SUM_W-1:0] sum_v;

    always_comb begin
        us_x = SUM_W'(us_v);
        pr_x = SUM_W'(pr_v);
        if (U_NEG) begin
            if (P_NEG) sum_v = -us_x - pr_x;
            else       sum_v = -us_x + pr_x;
        end else begin
            if (P_NEG) sum_v = us_x - pr_x;
            else       sum_v = us_x + pr_x;
        end
        met_v = OUT_W'(sum_v);
    end

endmodule

// File: rtl/bmu_ctrl.sv
// Two-state output controller: tracks whether the metric registers are fresh.
module bmu_ctrl
    import bmu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    output logic load_en,
    output logic fresh
);

    bmu_state_t state_q;
    bmu_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (step_in)  state_d = ST_STREAM;
            ST_STREAM: if (!step_in) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en = step_in;
        fresh   = 1'b0;
        unique case (state_q)
            ST_IDLE:   fresh = 1'b0;
            ST_STREAM: fresh = 1'b1;
            default:   fresh = 1'b0;
        endcase
    end

endmodule

// File: rtl/turbo_bmu.sv
module turbo_bmu
    import bmu_pkg::*;
#(
    parameter int unsigned CH_INT  = 2,
    parameter int unsigned CH_FRAC = 2,
    parameter int unsigned AP_INT  = 4,
    parameter int unsigned AP_FRAC = 2,
    parameter int unsigned OUT_INT = 4,
    localparam int unsigned CH_W     = 1 + CH_INT + CH_FRAC,
    localparam int unsigned AP_W     = 1 + AP_INT + AP_FRAC,
    localparam int unsigned ALN_FRAC = imax(CH_FRAC, AP_FRAC),
    localparam int unsigned OUT_W    = 1 + OUT_INT + ALN_FRAC + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [CH_W-1:0]  in_sys,
    input  logic signed [CH_W-1:0]  in_par,
    input  logic signed [AP_W-1:0]  in_apr,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_m_pp,
    output logic signed [OUT_W-1:0] out_m_pn,
    output logic signed [OUT_W-1:0] out_m_np,
    output logic signed [OUT_W-1:0] out_m_nn
);

    localparam int unsigned CH_SH     = ALN_FRAC - CH_FRAC;
    localparam int unsigned AP_SH     = ALN_FRAC - AP_FRAC;
    localparam int unsigned CH_A_W    = CH_W + CH_SH;
    localparam int unsigned AP_A_W    = AP_W + AP_SH;
    localparam int unsigned US_W      = imax(CH_A_W, AP_A_W) + 1;
    localparam int unsigned SUM_W     = imax(US_W, CH_A_W) + 1;
    localparam int unsigned MET_BOUND = (1 << (AP_A_W - 1)) + 2 * (1 << (CH_A_W - 1));

    logic signed [CH_A_W-1:0] sys_a;
    logic signed [CH_A_W-1:0] par_a;
    logic signed [AP_A_W-1:0] apr_a;
    logic signed [US_W-1:0]   us_sum;
    logic signed [OUT_W-1:0]  met_d [LBL_COUNT];
    logic signed [OUT_W-1:0]  met_q [LBL_COUNT];
    logic                     load_en;
    logic                     fresh;

    bmu_align #(.IN_W(CH_W), .SHIFT(CH_SH), .OUT_W(CH_A_W)) u_al_sys (.in_v(in_sys), .out_v(sys_a));
    bmu_align #(.IN_W(CH_W), .SHIFT(CH_SH), .OUT_W(CH_A_W)) u_al_par (.in_v(in_par), .out_v(par_a));
    bmu_align #(.IN_W(AP_W), .SHIFT(AP_SH), .OUT_W(AP_A_W)) u_al_apr (.in_v(in_apr), .out_v(apr_a));

    // systematic label equals u, so a-priori and systematic share one adder
    always_comb begin
        us_sum = US_W'(apr_a) + US_W'(sys_a);
    end

    for (genvar gi = 0; gi < LBL_COUNT; gi++) begin : g_lbl
        bmu_combine #(
            .US_W (US_W),
            .PR_W (CH_A_W),
            .SUM_W(SUM_W),
            .OUT_W(OUT_W),
            .U_NEG(((gi >> 1) & 1) != 0),
            .P_NEG((gi & 1) != 0)
        ) u_comb (
            .us_v (us_sum),
            .pr_v (par_a),
            .met_v(met_d[gi])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       met_q[gi] <= '0;
            else if (load_en) met_q[gi] <= met_d[gi];
        end
    end

    bmu_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_in(in_valid),
        .load_en(load_en),
        .fresh  (fresh)
    );

    always_comb begin
        out_valid = fresh;
        out_m_pp  = met_q[LBL_PP];
        out_m_pn  = met_q[LBL_PN];
        out_m_np  = met_q[LBL_NP];
        out_m_nn  = met_q[LBL_NN];
    end

endmodule

// File: rtl/turbo_bmu_chk.sv
module turbo_bmu_chk #(
    parameter int unsigned CH_W   = 5,
    parameter int unsigned OUT_W  = 8,
    parameter int unsigned PAR_SH = 0,
    parameter int unsigned BOUND  = 96
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic signed [CH_W-1:0]  in_par,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_m_pp,
    input logic signed [OUT_W-1:0] out_m_pn,
    input logic signed [OUT_W-1:0] out_m_np,
    input logic signed [OUT_W-1:0] out_m_nn
);

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_m_pp) && $stable(out_m_pn) && $stable(out_m_np) && $stable(out_m_nn))); // R7

    AST_PARITY_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (int'(out_m_pp) - int'(out_m_pn) == 2 * (int'($past(in_par)) * (1 << PAR_SH)))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (iabs(int'(out_m_pp)) <= int'(BOUND) && iabs(int'(out_m_nn)) <= int'(BOUND)
                       && iabs(int'(out_m_pn)) <= int'(BOUND) && iabs(int'(out_m_np)) <= int'(BOUND))); // R8

    AST_U_SYMMETRY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_m_nn) == -int'(out_m_pp) && int'(out_m_np) == -int'(out_m_pn))); // R9

endmodule

bind turbo_bmu turbo_bmu_chk #(
    .CH_W  (CH_W),
    .OUT_W (OUT_W),
    .PAR_SH(CH_SH),
    .BOUND (MET_BOUND)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_par   (in_par),
    .out_valid(out_valid),
    .out_m_pp (out_m_pp),
    .out_m_pn (out_m_pn),
    .out_m_np (out_m_np),
    .out_m_nn (out_m_nn)
);

// File: tb/turbo_bmu_bench.sv
module turbo_bmu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic signed [4:0] in_sys;
    logic signed [4:0] in_par;
    logic signed [6:0] in_apr;
    logic              out_valid;
    logic signed [7:0] out_m_pp;
    logic signed [7:0] out_m_pn;
    logic signed [7:0] out_m_np;
    logic signed [7:0] out_m_nn;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // behavioural reference state
    int e_pp = 0, e_pn = 0, e_np = 0, e_nn = 0;
    bit e_v = 0;
    bit e_ext = 0;
    bit in_rst_phase = 1;

    turbo_bmu u_turbo_bmu (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sys   (in_sys),
        .in_par   (in_par),
        .in_apr   (in_apr),
        .out_valid(out_valid),
        .out_m_pp (out_m_pp),
        .out_m_pn (out_m_pn),
        .out_m_np (out_m_np),
        .out_m_nn (out_m_nn)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_pp = 0; e_pn = 0; e_np = 0; e_nn = 0; e_v = 0; e_ext = 0;
        end else begin
            int a, s, p, us;
            e_v = in_valid;
            if (in_valid) begin
                a  = in_apr;
                s  = in_sys;
                p  = in_par;
                us = a + s;
                e_pp = us + p;
                e_pn = us - p;
                e_np = -us + p;
                e_nn = -us - p;
                e_ext = (a == -64 && s == -16 && p == -16) || (a == 63 && s == 15 && p == 15);
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (in_rst_phase) begin
            check("R1", "out_valid", int'(out_valid), 0);
            check("R1", "out_m_pp", int'(out_m_pp), 0);
            check("R1", "out_m_nn", int'(out_m_nn), 0);
        end else begin
            check("R6", "out_valid", int'(out_valid), int'(e_v));
            if (e_ext) begin
                check("R8", "out_m_pp", int'(out_m_pp), e_pp);
                check("R8", "out_m_nn", int'(out_m_nn), e_nn);
            end
            if (e_v) begin
                check("R2", "out_m_pp", int'(out_m_pp), e_pp);
                check("R3", "out_m_pn", int'(out_m_pn), e_pn);
                check("R4", "out_m_np", int'(out_m_np), e_np);
                check("R5", "out_m_nn", int'(out_m_nn), e_nn);
                check("R9", "nn+pp", int'(out_m_nn) + int'(out_m_pp), 0);
            end else begin
                check("R7", "out_m_pp", int'(out_m_pp), e_pp);
                check("R7", "out_m_pn", int'(out_m_pn), e_pn);
                check("R7", "out_m_np", int'(out_m_np), e_np);
                check("R7", "out_m_nn", int'(out_m_nn), e_nn);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step(input bit v, input int a, input int s, input int p);
        @(negedge clk);
        in_valid = v;
        in_apr   = 7'(a);
        in_sys   = 5'(s);
        in_par   = 5'(p);
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_apr   = 7'sd20;
        in_sys   = 5'sd7;
        in_par   = -5'sd3;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);              // R1: first cycle out of reset, still idle
        in_rst_phase = 0;
        // R2..R5 directed patterns
        step(1, 0, 0, 0);
        step(1, 4, 4, 4);
        step(1, -4, 8, -12);
        step(0, 63, -16, 15);        // R7: idle with garbage inputs
        step(0, -64, 15, -16);
        // R8: full-scale corners
        step(1, -64, -16, -16);
        step(1, 63, 15, 15);
        step(0, 0, 0, 0);
        step(1, -64, 15, -16);
        step(1, 63, -16, 15);
        // R6: isolated and back-to-back steps, random data
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 3) != 0, int'($urandom % 128) - 64,
                 int'($urandom % 32) - 16, int'($urandom % 32) - 16);
        end
        step(0, 5, 5, 5);
        step(0, -5, -5, -5);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule